// File: doc/BRIEF.md
# Sticky Protection-Violation Status Register

This block records protection-violation events from internal sources in sticky status bits that software reads later. There are two status registers. One holds the application-mode sources and one holds the debug-mode sources. An event counts only when its input rises and then stays high for two interface clock cycles. A glitch lasting a single cycle is dropped. After a bit is set, it stays set until it is cleared.

A simple register port gives access to both registers. A read in either privilege level returns the selected register. Only a privileged write changes state: it clears every bit whose write-data bit is 1. A one-cycle global clear input, pulsed when the firewall error logs are wiped, empties both registers at once.

Top module: `prot_viol_status`

## Requirements
- R1: A status bit is set only by a low-to-high transition of its event input. An input that stays high after its bit has been cleared does not set the bit again.
- R2: An event input that is high for exactly one cycle is not recorded. An input that is high for two or more consecutive cycles is recorded, and its bit reads 1 one cycle after the second high cycle.
- R3: A set bit keeps its value until it is cleared by a privileged write, the global clear or reset.
- R4: A write with `acc_priv`=1 clears, in the register chosen by `acc_sel` (0 = application, 1 = debug), each bit whose `acc_wdata` bit is 1. Bits written with 0, and the other register, are unchanged.
- R5: A one-cycle pulse on `fw_clr` clears every bit of both registers.
- R6: A write with `acc_priv`=0 has no effect. Reads return the selected register when `acc_en`=1 and `acc_wr`=0, whatever the value of `acc_priv`, and return 0 at all other times.
- R7: The application register implements only bit positions 0, 1, 2, 4, 6, 7, 12, 15, 16 and 17 (mask 0x390D7). Each of these bits is driven by `app_evt` at the same index. All other positions read 0.
- R8: The debug register implements only positions 0 and 1, driven by `dbg_evt`. Positions 2 to 31 read 0.
- R9: When a qualified event and a clear (privileged write or `fw_clr`) reach the same bit in the same cycle, the bit ends up set.
- R10: An active-low reset clears all status bits and all qualification history.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Interface clock |
| rst_n | input | 1 | Active-low reset, asynchronous assert |
| app_evt | input | 18 | Application-mode violation event inputs |
| dbg_evt | input | 2 | Debug-mode violation event inputs |
| fw_clr | input | 1 | One-cycle clear pulse from the firewall log clear |
| acc_en | input | 1 | Register access valid |
| acc_wr | input | 1 | 1 = write, 0 = read |
| acc_priv | input | 1 | 1 = privileged access |
| acc_sel | input | 1 | 0 = application register, 1 = debug register |
| acc_wdata | input | 32 | Write data, 1 bits clear status |
| rd_data | output | 32 | Read data, 0 when no read is active |

## Verification
The bench drives event pulses of one, two and many cycles. A design that records on level or ignores the two-cycle window would show bits after a single-cycle glitch, or would re-set a bit while an input stays high after it was cleared. It applies writes at both privilege levels to each register, which catches a design that lets public writes through, clears the wrong register or clears bits written with 0. It makes an event qualify in the same edge as `fw_clr`, where a design that favours the clear would lose the event. It drives all inputs high to expose any unimplemented position that can be set.

// File: rtl/prot_pkg.sv
package prot_pkg;
  localparam int unsigned DW        = 32;
  localparam int unsigned APP_EW    = 18;
  localparam int unsigned DBG_EW    = 2;
  localparam logic [DW-1:0] APP_MASK = 32'h0003_90D7;
  localparam logic [DW-1:0] DBG_MASK = 32'h0000_0003;
endpackage

// File: rtl/evt_qual.sv
module evt_qual #(
  parameter int unsigned W = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] evt_i,
  output logic [W-1:0] qual_o
);
  for (genvar i = 0; i < W; i++) begin : g_bit
    logic h1_q, h2_q;
    logic h1_d, h2_d;

    always_comb begin
      h1_d = evt_i[i];
      h2_d = h1_q;
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        h1_q <= 1'b0;
        h2_q <= 1'b0;
      end else begin
        h1_q <= h1_d;
        h2_q <= h2_d;
      end
    end

    assign qual_o[i] = evt_i[i] & h1_q & ~h2_q;

    // R2: a qualified edge needs the input high in this and the previous cycle
    a_r2_two_cycle_high: assert property (@(posedge clk) disable iff (!rst_n)
      qual_o[i] |-> (evt_i[i] && $past(evt_i[i])));
    // R1: one rising edge yields exactly one qualify pulse
    a_r1_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      qual_o[i] |=> !qual_o[i]);
  end
endmodule

// File: rtl/sticky_reg.sv
module sticky_reg #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] MASK = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic [W-1:0] clr_i,
  output logic [W-1:0] stat_o
);
  logic [W-1:0] stat_q, stat_d;
  logic         upd_en;

  always_comb begin
    upd_en = (|set_i) | (|clr_i);
    stat_d = ((stat_q & ~clr_i) | set_i) & MASK;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      stat_q <= '0;
    else if (upd_en) stat_q <= stat_d;
  end

  assign stat_o = stat_q;

  // R7 / R8: unimplemented positions never hold a 1
  a_r7_unimpl_zero: assert property (@(posedge clk) disable iff (!rst_n)
    (stat_q & ~MASK) == '0);
  // R3: without a clear, no set bit is lost
  a_r3_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_i == '0) |=> ((stat_q & $past(stat_q)) == $past(stat_q)));
  // R9: a qualified event always lands, even against a clear
  a_r9_set_wins: assert property (@(posedge clk) disable iff (!rst_n)
    (set_i != '0) |=> ((stat_q & $past(set_i & MASK)) == $past(set_i & MASK)));
endmodule

// File: rtl/prot_viol_status.sv
module prot_viol_status
  import prot_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [APP_EW-1:0] app_evt,
  input  logic [DBG_EW-1:0] dbg_evt,
  input  logic              fw_clr,
  input  logic              acc_en,
  input  logic              acc_wr,
  input  logic              acc_priv,
  input  logic              acc_sel,
  input  logic [DW-1:0]     acc_wdata,
  output logic [DW-1:0]     rd_data
);
  logic [APP_EW-1:0] app_q;
  logic [DBG_EW-1:0] dbg_q;
  logic [DW-1:0]     app_set, dbg_set, app_clr, dbg_clr, app_stat, dbg_stat;
  logic              priv_wr, rd_en;

  evt_qual #(.W(APP_EW)) u_app_q (.clk(clk), .rst_n(rst_n), .evt_i(app_evt), .qual_o(app_q));
  evt_qual #(.W(DBG_EW)) u_dbg_q (.clk(clk), .rst_n(rst_n), .evt_i(dbg_evt), .qual_o(dbg_q));

  always_comb begin
    app_set = {{(DW-APP_EW){1'b0}}, app_q};
    dbg_set = {{(DW-DBG_EW){1'b0}}, dbg_q};
    priv_wr = acc_en & acc_wr & acc_priv;
    rd_en   = acc_en & ~acc_wr;
    app_clr = fw_clr ? '1 : ((priv_wr && !acc_sel) ? acc_wdata : '0);
    dbg_clr = fw_clr ? '1 : ((priv_wr &&  acc_sel) ? acc_wdata : '0);
    if (!rd_en)       rd_data = '0;
    else if (acc_sel) rd_data = dbg_stat;
    else              rd_data = app_stat;
  end

  sticky_reg #(.W(DW), .MASK(APP_MASK)) u_app_r (
    .clk(clk), .rst_n(rst_n), .set_i(app_set), .clr_i(app_clr), .stat_o(app_stat));
  sticky_reg #(.W(DW), .MASK(DBG_MASK)) u_dbg_r (
    .clk(clk), .rst_n(rst_n), .set_i(dbg_set), .clr_i(dbg_clr), .stat_o(dbg_stat));

  // R6: a public write leaves both registers at least as full as before
  a_r6_public_write_ignored: assert property (@(posedge clk) disable iff (!rst_n)
    (acc_en && acc_wr && !acc_priv && !fw_clr)
      |=> (((app_stat & $past(app_stat)) == $past(app_stat)) &&
           ((dbg_stat & $past(dbg_stat)) == $past(dbg_stat))));
  // R5: after a global clear only same-cycle events survive
  a_r5_fw_clear: assert property (@(posedge clk) disable iff (!rst_n)
    fw_clr |=> ((app_stat == $past(app_set & APP_MASK)) &&
                (dbg_stat == $past(dbg_set & DBG_MASK))));
  // R4: a privileged write never touches the unselected register
  a_r4_other_reg_kept: assert property (@(posedge clk) disable iff (!rst_n)
    (priv_wr && !fw_clr && !acc_sel) |=> ((dbg_stat & $past(dbg_stat)) == $past(dbg_stat)));
endmodule

// File: tb/sim_prot_viol_status.sv
module sim_prot_viol_status;
  logic        clk, rst_n;
  logic [17:0] app_evt;
  logic [1:0]  dbg_evt;
  logic        fw_clr, acc_en, acc_wr, acc_priv, acc_sel;
  logic [31:0] acc_wdata, rd_data;
  int          n_chk, n_bad;

  prot_viol_status u0 (
    .clk(clk), .rst_n(rst_n), .app_evt(app_evt), .dbg_evt(dbg_evt), .fw_clr(fw_clr),
    .acc_en(acc_en), .acc_wr(acc_wr), .acc_priv(acc_priv), .acc_sel(acc_sel),
    .acc_wdata(acc_wdata), .rd_data(rd_data));

  initial clk = 1'b0;
  always #4 clk = ~clk;

  // op: 0 event (a=app, d=dbg, len cycles), 1 priv write, 2 public write (a=data, d=sel), 3 fw_clr
  localparam int NV = 12;
  localparam logic [135:0] VEC [NV] = '{
    {4'd0, 4'd1, 32'h1,     32'h0, 32'h0,     32'h0},  // R2 glitch
    {4'd0, 4'd2, 32'h1,     32'h0, 32'h1,     32'h0},  // R2 two cycles
    {4'd0, 4'd3, 32'h3FFFF, 32'h3, 32'h390D7, 32'h3},  // R7 R8
    {4'd2, 4'd0, 32'hFFFFFFFF, 32'h0, 32'h390D7, 32'h3}, // R6
    {4'd1, 4'd0, 32'h5,     32'h0, 32'h390D2, 32'h3},  // R4
    {4'd1, 4'd0, 32'h1,     32'h1, 32'h390D2, 32'h2},  // R4 debug
    {4'd3, 4'd0, 32'h0,     32'h0, 32'h0,     32'h0},  // R5
    {4'd0, 4'd2, 32'h10000, 32'h0, 32'h10000, 32'h0},  // R7
    {4'd0, 4'd8, 32'h2,     32'h0, 32'h10002, 32'h0},  // R1 R3
    {4'd1, 4'd0, 32'hFFFFFFFF, 32'h0, 32'h0,  32'h0},  // R4
    {4'd0, 4'd1, 32'h0,     32'h1, 32'h0,     32'h0},  // R2 debug glitch
    {4'd0, 4'd2, 32'h0,     32'h1, 32'h0,     32'h1}   // R2 debug
  };

  task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic rd(input logic sel, input logic priv, output logic [31:0] v);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b0; acc_sel = sel; acc_priv = priv;
    #2 v = rd_data;
    @(negedge clk);
    acc_en = 1'b0;
  endtask

  task automatic wr(input logic sel, input logic priv, input logic [31:0] d);
    @(negedge clk);
    acc_en = 1'b1; acc_wr = 1'b1; acc_sel = sel; acc_priv = priv; acc_wdata = d;
    @(negedge clk);
    acc_en = 1'b0; acc_wr = 1'b0; acc_wdata = '0;
  endtask

  task automatic pulse(input logic [17:0] a, input logic [1:0] d, input int len);
    @(negedge clk);
    app_evt = a; dbg_evt = d;
    repeat (len) @(negedge clk);
    app_evt = '0; dbg_evt = '0;
    repeat (2) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] v;
    n_chk = 0; n_bad = 0;
    rst_n = 1'b0; app_evt = '0; dbg_evt = '0; fw_clr = 1'b0;
    acc_en = 1'b0; acc_wr = 1'b0; acc_priv = 1'b0; acc_sel = 1'b0; acc_wdata = '0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    rd(1'b0, 1'b0, v); check("R10 reset app", v, 32'h0);
    rd(1'b1, 1'b0, v); check("R10 reset dbg", v, 32'h0);

    for (int i = 0; i < NV; i++) begin
      logic [135:0] e;
      e = VEC[i];
      case (e[135:132])
        4'd0: pulse(e[113:96], e[65:64], int'(e[131:128]));
        4'd1: wr(e[64], 1'b1, e[127:96]);
        4'd2: wr(e[64], 1'b0, e[127:96]);
        default: begin
          @(negedge clk); fw_clr = 1'b1;
          @(negedge clk); fw_clr = 1'b0;
        end
      endcase
      rd(1'b0, 1'b0, v); check($sformatf("vector %0d app R1-7 table", i), v, e[63:32]);
      rd(1'b1, 1'b1, v); check($sformatf("vector %0d dbg R8 table", i), v, e[31:0]);
    end

    // R1: level held high does not re-set after a clear
    @(negedge clk); app_evt = 18'h10;
    repeat (3) @(negedge clk);
    rd(1'b0, 1'b0, v); check("R1 edge sets", v, 32'h10);
    wr(1'b0, 1'b1, 32'h10);
    repeat (3) @(negedge clk);
    rd(1'b0, 1'b0, v); check("R1 level no reset", v, 32'h0);
    app_evt = '0;
    repeat (2) @(negedge clk);

    // R6: idle read port returns zero
    #2 check("R6 idle read zero", rd_data, 32'h0);

    // R9: event qualifies on the same edge as fw_clr
    pulse(18'h1, 2'b0, 2);
    @(negedge clk); app_evt = 18'h40;
    @(negedge clk); fw_clr = 1'b1;
    @(negedge clk); fw_clr = 1'b0; app_evt = '0;
    rd(1'b0, 1'b0, v); check("R9 set wins fw_clr", v, 32'h40);

    // R9: event qualifies on the same edge as a privileged clear of that bit
    @(negedge clk); dbg_evt = 2'b10;
    @(negedge clk); acc_en = 1'b1; acc_wr = 1'b1; acc_priv = 1'b1; acc_sel = 1'b1; acc_wdata = 32'h3;
    @(negedge clk); acc_en = 1'b0; acc_wr = 1'b0; dbg_evt = '0;
    rd(1'b1, 1'b0, v); check("R9 set wins write", v, 32'h2);

    // R10: reset empties both registers
    @(negedge clk); rst_n = 1'b0;
    @(negedge clk); rst_n = 1'b1;
    rd(1'b0, 1'b0, v); check("R10 reset clears app", v, 32'h0);
    rd(1'b1, 1'b0, v); check("R10 reset clears dbg", v, 32'h0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule